// File: doc/BRIEF.md
# Accumulator Processor Core, 24-bit Word

This block is a compact multi-cycle processor built around one 24-bit accumulator. It fetches fixed three-byte instructions from a byte-wide synchronous memory port and decodes each into an operation code, an index flag and a 15-bit address. It then either moves a word or byte between memory and a register, performs arithmetic or a comparison against a memory operand, changes the flow of control, or exchanges one byte with an external device.

The core keeps the accumulator A, the index register X, the link register L, a 15-bit program counter and a three-way condition code. Every memory transfer is one byte per cycle, so a word access costs three port cycles. An unrecognised operation code stops the machine and raises `halt` until the next reset. The surrounding system supplies a memory with one cycle of read latency and a device port with a ready level and single-cycle read and write strobes.

Top module: `acc24_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, A, X, L and the program counter clear to zero, the condition code becomes "equal", `halt` and `div_err` drop to 0, and no write is issued; in the first cycle after reset the core reads address 0.
- R2: An instruction is three bytes read at increasing addresses: byte 0 is the operation code, bit 7 of byte 1 is the index flag, and bits 6..0 of byte 1 with all of byte 2 form the 15-bit address field (most significant first). Data words are also stored most significant byte at the lowest address, and read data is sampled one cycle after the read strobe.
- R3: The target address is the address field, plus X when the index flag is 1, kept to 15 bits (wrapping modulo 2^15).
- R4: Operation codes 0x00, 0x04, 0x08 load A, X, L from the target word; 0x0C, 0x10, 0x14 store A, X, L to it; 0x50 loads the target byte into bits 7..0 of A leaving bits 23..8 unchanged; 0x54 stores bits 7..0 of A to the target byte.
- R5: Codes 0x18, 0x1C, 0x20 replace A with A plus, A minus, and A times the memory word, keeping the low 24 bits of the two's complement result.
- R6: Code 0x24 replaces A with the signed quotient of A by the memory word, truncated toward zero; a zero divisor leaves A unchanged and sets `div_err`, which stays set until reset.
- R7: Code 0x28 compares A with the memory word as signed values and sets the condition code to less, equal or greater; 0x38, 0x30, 0x34 jump to the target only on less, equal, greater respectively, and 0x3C always jumps.
- R8: Code 0x2C adds one to X, then compares the new X with the memory word as signed values and sets the condition code.
- R9: Code 0x48 writes the address of the following instruction into L and jumps to the target; code 0x4C jumps to the address held in the low 15 bits of L.
- R10: With the device number on `dev_sel` equal to bits 7..0 of the target address, code 0xE0 sets the condition code to less when `dev_ready` is 1 and to equal otherwise; 0xD8 pulses `dev_rd` and loads `dev_rdata` into bits 7..0 of A; 0xDC pulses `dev_wr` with bits 7..0 of A on `dev_wdata`.
- R11: Any other operation code raises `halt`, which stays high, and the core then issues no memory read or write until reset.
- R12: The memory port never has read and write strobes high in the same cycle, and the device port never strobes read and write together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address for the current memory cycle |
| mem_rd_en | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by the memory |
| dev_sel | output | 8 | Number of the device being addressed |
| dev_ready | input | 1 | Selected device can transfer a byte |
| dev_rd | output | 1 | One-cycle strobe taking a byte from the device |
| dev_wr | output | 1 | One-cycle strobe handing a byte to the device |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte offered by the device |
| halt | output | 1 | Core stopped on an unknown operation code |
| div_err | output | 1 | Sticky flag: a division by zero was attempted |

## Verification
The arithmetic and compare path is driven by a short program whose operands and operation are drawn at random, alongside directed pairs for equal values, signed wrap at the positive and negative limits and a zero divisor; storing the result and a branch marker separates wrong arithmetic, wrong signedness of the compare and wrong branch selection. A second program copies a byte table through an indexed loop closed by the increment-and-compare instruction, calls a subroutine and talks to a device, which tells apart faults in indexing, loop exit, return address and byte placement in A. It is run once with the device ready and once busy, so the test result itself, not the I/O path, decides whether the transfer happens.

// File: rtl/acc24_pkg.sv
// Shared constants and types for the 24-bit accumulator core.
// Assumes an instruction word is exactly opcode + index flag + address field.
package acc24_pkg;
    parameter int WORD_W = 24;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = 15;
    localparam int WBYTES = WORD_W / BYTE_W;
    localparam int CNT_W  = $clog2(WBYTES + 1);

    localparam logic [7:0] OP_LDA  = 8'h00;
    localparam logic [7:0] OP_LDX  = 8'h04;
    localparam logic [7:0] OP_LDL  = 8'h08;
    localparam logic [7:0] OP_STA  = 8'h0C;
    localparam logic [7:0] OP_STX  = 8'h10;
    localparam logic [7:0] OP_STL  = 8'h14;
    localparam logic [7:0] OP_ADD  = 8'h18;
    localparam logic [7:0] OP_SUB  = 8'h1C;
    localparam logic [7:0] OP_MUL  = 8'h20;
    localparam logic [7:0] OP_DIV  = 8'h24;
    localparam logic [7:0] OP_COMP = 8'h28;
    localparam logic [7:0] OP_TIX  = 8'h2C;
    localparam logic [7:0] OP_JEQ  = 8'h30;
    localparam logic [7:0] OP_JGT  = 8'h34;
    localparam logic [7:0] OP_JLT  = 8'h38;
    localparam logic [7:0] OP_J    = 8'h3C;
    localparam logic [7:0] OP_JSUB = 8'h48;
    localparam logic [7:0] OP_RSUB = 8'h4C;
    localparam logic [7:0] OP_LDCH = 8'h50;
    localparam logic [7:0] OP_STCH = 8'h54;
    localparam logic [7:0] OP_RD   = 8'hD8;
    localparam logic [7:0] OP_WD   = 8'hDC;
    localparam logic [7:0] OP_TD   = 8'hE0;

    typedef enum logic [1:0] {CC_EQ = 2'b00, CC_LT = 2'b01, CC_GT = 2'b10} cc_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_RDMEM, ST_WRMEM, ST_EXEC, ST_HALT
    } state_t;

    // Memory traffic class of one operation code
    typedef struct packed {
        logic legal;
        logic rd;
        logic wr;
        logic one_byte;
    } opclass_t;
endpackage

// File: rtl/acc24_decode.sv
// Classifies an operation code: legal or not, memory read or write, byte or word.
// Assumes: pure combinational, no state.
module acc24_decode
    import acc24_pkg::*;
(
    input  logic [7:0] opcode,
    output opclass_t   cls
);
    // Map each code to its memory traffic class
    always_comb begin
        cls = '0;
        unique case (opcode)
            OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL, OP_DIV,
            OP_COMP, OP_TIX:
                cls = '{legal: 1'b1, rd: 1'b1, wr: 1'b0, one_byte: 1'b0};
            OP_LDCH:
                cls = '{legal: 1'b1, rd: 1'b1, wr: 1'b0, one_byte: 1'b1};
            OP_STA, OP_STX, OP_STL:
                cls = '{legal: 1'b1, rd: 1'b0, wr: 1'b1, one_byte: 1'b0};
            OP_STCH:
                cls = '{legal: 1'b1, rd: 1'b0, wr: 1'b1, one_byte: 1'b1};
            OP_JEQ, OP_JGT, OP_JLT, OP_J, OP_JSUB, OP_RSUB,
            OP_RD, OP_WD, OP_TD:
                cls = '{legal: 1'b1, rd: 1'b0, wr: 1'b0, one_byte: 1'b0};
            default:
                cls = '0;
        endcase
    end
endmodule

// File: rtl/acc24_alu.sv
// Arithmetic and comparison for the accumulator core.
// Assumes two's complement operands; comparisons are signed; results keep low W bits.
module acc24_alu
    import acc24_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [7:0]   opcode,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] idx,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result,
    output logic [W-1:0] idx_inc,
    output cc_t          cc,
    output logic         div_zero
);
    logic [W-1:0] cmp_lhs;

    // Signed three-way compare of two words
    function automatic cc_t cmp3(input logic [W-1:0] l, input logic [W-1:0] r);
        if ($signed(l) < $signed(r))      return CC_LT;
        else if (l == r)                  return CC_EQ;
        else                              return CC_GT;
    endfunction

    assign idx_inc  = idx + W'(1);
    assign div_zero = (opnd == '0);
    assign cmp_lhs  = (opcode == OP_TIX) ? idx_inc : acc;
    assign cc       = cmp3(cmp_lhs, opnd);

    // Select the arithmetic result for A
    always_comb begin
        unique case (opcode)
            OP_ADD:  result = acc + opnd;
            OP_SUB:  result = acc - opnd;
            OP_MUL:  result = acc * opnd;
            OP_DIV:  result = div_zero ? acc : W'($signed(acc) / $signed(opnd));
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc24_cond.sv
// Decides whether a control-transfer code changes the program counter.
// Assumes only jump and linkage codes ever reach take = 1.
module acc24_cond
    import acc24_pkg::*;
(
    input  logic [7:0] opcode,
    input  cc_t        cc,
    output logic       take
);
    // Match the condition code against the jump kind
    always_comb begin
        unique case (opcode)
            OP_JLT:               take = (cc == CC_LT);
            OP_JEQ:               take = (cc == CC_EQ);
            OP_JGT:               take = (cc == CC_GT);
            OP_J, OP_JSUB:        take = 1'b1;
            default:              take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc24_core.sv
// Multi-cycle accumulator processor: fetch three bytes, decode, optional memory
// read or write one byte per cycle, execute. Assumes memory read data arrives one
// cycle after the read strobe and writes complete in the strobe cycle.
module acc24_core
    import acc24_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [7:0]          dev_sel,
    input  logic                dev_ready,
    output logic                dev_rd,
    output logic                dev_wr,
    output logic [BYTE_W-1:0]   dev_wdata,
    input  logic [BYTE_W-1:0]   dev_rdata,
    output logic                halt,
    output logic                div_err
);
    localparam int OPC_LSB = WORD_W - 8;

    state_t               state;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     nbytes;
    logic [WORD_W-1:0]    ir, opw, wbuf;
    logic [WORD_W-1:0]    reg_a, reg_x, reg_l;
    logic [ADDR_W-1:0]    pc, ta_q, ta;
    cc_t                  cc;
    logic                 err_q;

    logic [7:0]           opcode;
    opclass_t             cls;
    logic [WORD_W-1:0]    alu_res, x_inc;
    cc_t                  alu_cc;
    logic                 alu_dz, jmp_take;

    assign opcode = ir[OPC_LSB +: 8];
    // Target address: field plus X when indexed, wrapping at ADDR_W bits
    assign ta = ir[ADDR_W-1:0] + (ir[ADDR_W] ? reg_x[ADDR_W-1:0] : '0);

    acc24_decode u_dec (.opcode(opcode), .cls(cls));

    acc24_alu #(.W(WORD_W)) u_alu (
        .opcode(opcode), .acc(reg_a), .idx(reg_x), .opnd(opw),
        .result(alu_res), .idx_inc(x_inc), .cc(alu_cc), .div_zero(alu_dz)
    );

    acc24_cond u_cond (.opcode(opcode), .cc(cc), .take(jmp_take));

    // Memory port drive for fetch, operand read and store phases
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = ta_q + ADDR_W'(cnt);
        mem_wdata = wbuf[WORD_W-1 -: BYTE_W];
        unique case (state)
            ST_FETCH: begin
                mem_addr  = pc + ADDR_W'(cnt);
                mem_rd_en = (cnt < CNT_W'(WBYTES));
            end
            ST_RDMEM: mem_rd_en = (cnt < nbytes);
            ST_WRMEM: mem_wr_en = 1'b1;
            default: ;
        endcase
    end

    assign dev_sel   = ta_q[7:0];
    assign dev_rd    = (state == ST_EXEC) && (opcode == OP_RD);
    assign dev_wr    = (state == ST_EXEC) && (opcode == OP_WD);
    assign dev_wdata = reg_a[BYTE_W-1:0];
    assign halt      = (state == ST_HALT);
    assign div_err   = err_q;

    // Sequencer and architectural register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FETCH;
            cnt    <= '0;
            nbytes <= '0;
            ir     <= '0;
            opw    <= '0;
            wbuf   <= '0;
            reg_a  <= '0;
            reg_x  <= '0;
            reg_l  <= '0;
            pc     <= '0;
            ta_q   <= '0;
            cc     <= CC_EQ;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (cnt != '0) ir <= {ir[WORD_W-BYTE_W-1:0], mem_rdata};
                    if (cnt == CNT_W'(WBYTES)) begin
                        cnt   <= '0;
                        state <= ST_DECODE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DECODE: begin
                    ta_q   <= ta;
                    pc     <= pc + ADDR_W'(WBYTES);
                    opw    <= '0;
                    nbytes <= cls.one_byte ? CNT_W'(1) : CNT_W'(WBYTES);
                    unique case (opcode)
                        OP_STX:  wbuf <= reg_x;
                        OP_STL:  wbuf <= reg_l;
                        OP_STCH: wbuf <= {reg_a[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
                        default: wbuf <= reg_a;
                    endcase
                    if (!cls.legal)  state <= ST_HALT;
                    else if (cls.rd) state <= ST_RDMEM;
                    else if (cls.wr) state <= ST_WRMEM;
                    else             state <= ST_EXEC;
                end
                ST_RDMEM: begin
                    if (cnt != '0) opw <= {opw[WORD_W-BYTE_W-1:0], mem_rdata};
                    if (cnt == nbytes) begin
                        cnt   <= '0;
                        state <= ST_EXEC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WRMEM: begin
                    wbuf <= {wbuf[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                    if (cnt == nbytes - 1'b1) begin
                        cnt   <= '0;
                        state <= ST_FETCH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    unique case (opcode)
                        OP_LDA:  reg_a <= opw;
                        OP_LDX:  reg_x <= opw;
                        OP_LDL:  reg_l <= opw;
                        OP_LDCH: reg_a[BYTE_W-1:0] <= opw[BYTE_W-1:0];
                        OP_ADD, OP_SUB, OP_MUL: reg_a <= alu_res;
                        OP_DIV: begin
                            if (alu_dz) err_q <= 1'b1;
                            else        reg_a <= alu_res;
                        end
                        OP_COMP: cc <= alu_cc;
                        OP_TIX: begin
                            reg_x <= x_inc;
                            cc    <= alu_cc;
                        end
                        OP_JSUB: begin
                            reg_l <= WORD_W'(pc);
                            pc    <= ta_q;
                        end
                        OP_RSUB: pc <= reg_l[ADDR_W-1:0];
                        OP_TD:   cc <= dev_ready ? CC_LT : CC_EQ;
                        OP_RD:   reg_a[BYTE_W-1:0] <= dev_rdata;
                        default: if (jmp_take) pc <= ta_q;
                    endcase
                end
                default: state <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/acc24_core_chk.sv
// Port-level temporal checks for acc24_core, attached by bind below.
// Assumes it only observes; it drives nothing.
module acc24_core_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd_en,
    input logic mem_wr_en,
    input logic dev_rd,
    input logic dev_wr,
    input logic halt,
    input logic div_err
);
    AST_HALT_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) halt |=> halt); // R11
    AST_HALT_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) halt |-> !(mem_rd_en || mem_wr_en)); // R11
    AST_DIVERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) div_err |=> div_err); // R6
    AST_MEM_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_en && mem_wr_en)); // R12
    AST_DEV_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(dev_rd && dev_wr)); // R12
    AST_DEV_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) dev_wr |=> !dev_wr); // R10
    AST_RESET_CLEAR:  assert property (@(posedge clk) !rst_n |=> !halt && !div_err && !mem_wr_en); // R1
endmodule

bind acc24_core acc24_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .halt(halt), .div_err(div_err)
);

// File: tb/sim_acc24_core.sv
// Bench for acc24_core: random arithmetic/compare programs plus directed
// indexing, subroutine and device programs, checked at stored memory results.
module sim_acc24_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  dev_sel, dev_wdata;
    logic        dev_ready, dev_rd, dev_wr;
    logic [7:0]  dev_rdata = 8'h5A;
    logic        halt, div_err;

    logic [7:0]  mem [0:4095];
    int          checks = 0;
    int          fails = 0;
    int          both_strobes = 0;
    int          wr_count = 0;
    logic [7:0]  wr_byte;
    logic [7:0]  wr_dev;

    localparam logic [7:0] C_LDA=8'h00, C_LDX=8'h04, C_STA=8'h0C, C_STX=8'h10,
        C_STL=8'h14, C_ADD=8'h18, C_SUB=8'h1C, C_MUL=8'h20, C_DIV=8'h24,
        C_COMP=8'h28, C_TIX=8'h2C, C_JEQ=8'h30, C_JLT=8'h38, C_J=8'h3C,
        C_JSUB=8'h48, C_RSUB=8'h4C, C_LDCH=8'h50, C_STCH=8'h54, C_RD=8'hD8,
        C_WD=8'hDC, C_TD=8'hE0, C_BAD=8'hFF;

    always #5 clk = ~clk;

    acc24_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_ready(dev_ready), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .halt(halt), .div_err(div_err)
    );

    // Memory model: one-cycle read latency, write in strobe cycle; device capture
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_rd_en && mem_wr_en) both_strobes <= both_strobes + 1;
        if (dev_rd && dev_wr) both_strobes <= both_strobes + 1;
        if (dev_wr) begin
            wr_count <= wr_count + 1;
            wr_byte  <= dev_wdata;
            wr_dev   <= dev_sel;
        end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ins(input int at, input logic [7:0] op, input logic x, input logic [14:0] a);
        mem[at] = op; mem[at+1] = {x, a[14:8]}; mem[at+2] = a[7:0];
    endtask

    task automatic putw(input int at, input logic [23:0] w);
        mem[at] = w[23:16]; mem[at+1] = w[15:8]; mem[at+2] = w[7:0];
    endtask

    function automatic logic [23:0] getw(input int at);
        return {mem[at], mem[at+1], mem[at+2]};
    endfunction

    function automatic logic [23:0] exp_arith(input logic [7:0] op, input logic [23:0] p, input logic [23:0] q);
        logic signed [24:0] sp, sq;
        sp = {p[23], p}; sq = {q[23], q};
        case (op)
            C_ADD:   return p + q;
            C_SUB:   return p - q;
            C_MUL:   return 24'(p * q);
            default: return (q == 0) ? p : 24'(sp / sq);
        endcase
    endfunction

    function automatic logic [23:0] exp_mark(input logic [23:0] p, input logic [23:0] q);
        if ($signed(p) < $signed(q)) return 24'd1;
        if (p == q)                  return 24'd2;
        return 24'd3;
    endfunction

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input string tag);
        int n = 0;
        rst_n = 1'b1;
        while (!halt && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!halt) begin
            checks++; fails++;
            $display("FAIL R11 %s run did not halt actual=0 expected=1", tag);
        end
    endtask

    // Arithmetic op on P,Q then compare-and-branch marker into RX
    task automatic arith_run(input logic [7:0] op, input logic [23:0] p, input logic [23:0] q);
        hold_reset();
        ins(0, C_LDA, 0, 15'h100);  ins(3, op, 0, 15'h103);  ins(6, C_STA, 0, 15'h106);
        ins(9, C_LDA, 0, 15'h100);  ins(12, C_COMP, 0, 15'h103);
        ins(15, C_JLT, 0, 15'd27);  ins(18, C_JEQ, 0, 15'd33);
        ins(21, C_LDX, 0, 15'h112); ins(24, C_J, 0, 15'd36);
        ins(27, C_LDX, 0, 15'h10C); ins(30, C_J, 0, 15'd36);
        ins(33, C_LDX, 0, 15'h10F); ins(36, C_STX, 0, 15'h109);
        ins(39, C_BAD, 0, 15'h0);
        putw(12'h100, p); putw(12'h103, q);
        putw(12'h10C, 24'd1); putw(12'h10F, 24'd2); putw(12'h112, 24'd3);
        run_prog("arith");
        chk((op == C_DIV) ? "R6 quotient" : "R5 result", getw(12'h106), exp_arith(op, p, q));
        chk("R7 branch marker", getw(12'h109), exp_mark(p, q));
        chk("R6 div_err flag", {23'd0, div_err}, {23'd0, (op == C_DIV) && (q == 0)});
    endtask

    // Indexed byte copy with TIX loop, subroutine call, device test/read/write
    task automatic misc_run(input logic ready, input logic [31:0] tbl);
        hold_reset();
        dev_ready = ready;
        ins(0, C_LDX, 0, 15'h200);  ins(3, C_LDCH, 1, 15'h210);
        ins(6, C_STCH, 1, 15'h220); ins(9, C_TIX, 0, 15'h203);
        ins(12, C_JLT, 0, 15'd3);   ins(15, C_JSUB, 0, 15'd60);
        ins(18, C_STA, 0, 15'h20C); ins(21, C_STL, 0, 15'h206);
        ins(24, C_TD, 0, 15'h0F5);  ins(27, C_JEQ, 0, 15'd36);
        ins(30, C_RD, 0, 15'h0F5);  ins(33, C_WD, 0, 15'h0F5);
        ins(36, C_STA, 0, 15'h20F); ins(39, C_BAD, 0, 15'h0);
        ins(60, C_LDA, 0, 15'h209); ins(63, C_RSUB, 0, 15'h0);
        putw(12'h200, 24'd0); putw(12'h203, 24'd4); putw(12'h209, 24'h123407);
        {mem[12'h210], mem[12'h211], mem[12'h212], mem[12'h213]} = tbl;
        mem[12'h224] = 8'hEE;
        wr_count = 0;
        run_prog("misc");
        chk("R3 R4 indexed byte copy", {mem[12'h221], mem[12'h222], mem[12'h223]}, tbl[23:0]);
        chk("R4 byte copy first", {16'd0, mem[12'h220]}, {16'd0, tbl[31:24]});
        chk("R8 loop exit leaves next byte", {16'd0, mem[12'h224]}, 24'h0000EE);
        chk("R9 link register", getw(12'h206), 24'd18);
        chk("R9 subroutine result", getw(12'h20C), 24'h123407);
        if (ready) begin
            chk("R10 RD into low byte", getw(12'h20F), 24'h12345A);
            chk("R10 WD count", 24'(wr_count), 24'd1);
            chk("R10 WD byte", {16'd0, wr_byte}, 24'h00005A);
            chk("R10 device number", {16'd0, wr_dev}, 24'h0000F5);
        end else begin
            chk("R10 busy skips RD", getw(12'h20F), 24'h123407);
            chk("R10 busy no WD", 24'(wr_count), 24'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] ops [4] = '{C_ADD, C_SUB, C_MUL, C_DIV};
        void'($urandom(32'd1234));
        dev_ready = 1'b1;
        hold_reset();
        @(negedge clk);
        chk("R1 halt low in reset", {23'd0, halt}, 24'd0);
        chk("R1 div_err low in reset", {23'd0, div_err}, 24'd0);
        rst_n = 1'b1;
        chk("R1 R2 first read at address 0", {8'd0, mem_rd_en, mem_addr}, {8'd0, 1'b1, 15'd0});
        @(negedge clk);
        // Directed corner cases
        arith_run(C_DIV, 24'd1000, 24'd0);
        arith_run(C_ADD, 24'h7FFFFF, 24'd1);
        arith_run(C_SUB, 24'h800000, 24'd1);
        arith_run(C_SUB, 24'd55, 24'd55);
        arith_run(C_DIV, 24'hFFFFF9, 24'd2);
        arith_run(C_MUL, 24'hFFFFFD, 24'd7);
        // Random operations and operands
        for (int i = 0; i < 24; i++) begin
            logic [7:0]  op;
            logic [23:0] p, q;
            op = ops[$urandom % 4];
            p  = 24'($urandom);
            q  = (i % 3 == 0) ? 24'($urandom % 50) - 24'd25 : 24'($urandom);
            if (p == 24'h800000 && q == 24'hFFFFFF) q = 24'd3;
            arith_run(op, p, q);
        end
        misc_run(1'b1, $urandom);
        misc_run(1'b0, $urandom);
        chk("R11 halt held", {23'd0, halt}, 24'd1);
        chk("R12 strobe overlap count", 24'(both_strobes), 24'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule